// File: doc/BRIEF.md
# Strided Vector Load Bank Scheduler

This block carries out one strided vector load. It takes a base word address, a stride and an element count. It computes the word address of each element and sends those addresses, in element order, to sixteen word-interleaved memory banks. A bank is chosen by the low four bits of the word address. After a bank takes a request it needs four cycles before it can take the next one, so the stride decides how often the issue stage has to wait.

Each bank answers a fixed twelve cycles after it is asked. The block keeps a short tag pipeline that records which bank and which element index each request carries. When the answer arrives, the word goes straight out on the vector register write port, tagged with its element index. Requests leave in element order and the latency is fixed, so results come back in element order with no reorder storage.

One command runs at a time. The command port is ready only when the unit is idle. A done flag rises once the last element has been written back.

Top module: `strided_load_sched`

## Requirements
- R1: At most one bit of `bank_req` is high in any cycle, and that bit is bank number `bank_addr[3:0]`. Word address w belongs to bank w mod 16.
- R2: Element i is requested at word address base + i*stride, computed modulo 2^32. A stride of 0xFFFFFFFF steps down by one word.
- R3: Once a bank has been requested in cycle c, it is not requested again before cycle c+4.
- R4: Elements are requested in index order, at most one per cycle. Element i is issued in the first cycle that is both after the issue of element i-1 and at least 4 cycles after the previous request to its bank. The first element goes out in the cycle after the command is accepted.
- R5: When the stride is a multiple of 16, consecutive elements are issued exactly 4 cycles apart.
- R6: When the stride is odd, N elements are issued in N consecutive cycles.
- R7: Element i appears on the write port exactly 12 cycles after its request. At that point `wb_valid` is high, `wb_idx` = i and `wb_data` holds the word returned by its bank. Write-backs occur in index order.
- R8: `cmd_ready` is high only while the unit is idle, and a `cmd_valid` seen while it is busy is ignored. `done` rises at the clock edge that takes the last write-back and stays high until the next command is accepted.
- R9: A length of 0 issues no requests and sets `done` at the accepting edge. A length above 64 is treated as 64.
- R10: After reset, `cmd_ready` = 1, `done` = 0, `bank_req` = 0 and `wb_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a load (taken when `cmd_ready`) |
| cmd_base | input | 32 | Word address of element 0 |
| cmd_stride | input | 32 | Word step between elements, two's complement |
| cmd_len | input | 7 | Element count, 0..64 (larger values clamped) |
| cmd_ready | output | 1 | Unit idle, command accepted |
| done | output | 1 | Last element written back |
| bank_req | output | 16 | One-hot request to a bank |
| bank_addr | output | 32 | Word address of the current request |
| bank_rvalid | input | 16 | Bank answer valid, 12 cycles after request |
| bank_rdata | input | 1024 | Bank answer words, bank b at bits [64b+63:64b] |
| wb_valid | output | 1 | Element write strobe |
| wb_idx | output | 6 | Element index being written |
| wb_data | output | 64 | Element data |

## Verification
On every cycle the assertions check four things: requests are one-hot, a bank is never asked twice within its busy window, consecutive request addresses differ by the stride, and each write-back meets a bank answer, carries the next index in sequence and never occurs while the unit reports itself idle. Other behaviours depend on the whole command and only the bench scenarios can show them. These are the exact issue cycles each stride produces (full rate for odd strides, one per four cycles for multiples of 16, the two-on-two-off pattern of stride 8), address wrap at the top of the space, the clamp of long lengths, the empty load, and a command offered while busy being dropped.

// File: rtl/strided_load_sched.sv
module strided_load_sched #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int MAXVL = 64,
  localparam int BW = $clog2(NBANK),
  localparam int CW = (BUSY > 1) ? $clog2(BUSY) : 1,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int IW = $clog2(MAXVL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [AW-1:0]       cmd_base,
  input  logic [AW-1:0]       cmd_stride,
  input  logic [LW-1:0]       cmd_len,
  output logic                cmd_ready,
  output logic                done,
  output logic [NBANK-1:0]    bank_req,
  output logic [AW-1:0]       bank_addr,
  input  logic [NBANK-1:0]    bank_rvalid,
  input  logic [NBANK*DW-1:0] bank_rdata,
  output logic                wb_valid,
  output logic [IW-1:0]       wb_idx,
  output logic [DW-1:0]       wb_data
);

  logic              active;
  logic [AW-1:0]     addr_q, stride_q;
  logic [LW-1:0]     len_q, iss_n, ret_n;
  logic [NBANK-1:0]  bank_free;
  logic [LAT-1:0]    tv_q;
  logic [BW-1:0]     tb_q [LAT];
  logic [IW-1:0]     ti_q [LAT];

  wire [BW-1:0] cur_bank = addr_q[BW-1:0];
  wire          take     = cmd_valid && !active;
  wire          issue    = active && (iss_n != len_q) && bank_free[cur_bank];
  wire [LW-1:0] len_eff  = (cmd_len > LW'(MAXVL)) ? LW'(MAXVL) : cmd_len;
  wire          last_wb  = wb_valid && (ret_n == len_q - 1'b1);

  assign cmd_ready = !active;
  assign bank_addr = addr_q;
  assign bank_req  = issue ? (NBANK'(1) << cur_bank) : '0;
  assign wb_valid  = tv_q[LAT-1];
  assign wb_idx    = ti_q[LAT-1];

  always_comb begin
    wb_data = '0;
    for (int b = 0; b < NBANK; b++)
      if (tb_q[LAT-1] == BW'(b)) wb_data = bank_rdata[b*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      addr_q <= '0;
      stride_q <= '0;
      len_q  <= '0;
      iss_n  <= '0;
      ret_n  <= '0;
    end else if (take) begin
      active   <= (len_eff != '0);
      done     <= (len_eff == '0);
      addr_q   <= cmd_base;
      stride_q <= cmd_stride;
      len_q    <= len_eff;
      iss_n    <= '0;
      ret_n    <= '0;
    end else begin
      if (issue) begin
        addr_q <= addr_q + stride_q;
        iss_n  <= iss_n + 1'b1;
      end
      if (wb_valid) ret_n <= ret_n + 1'b1;
      if (last_wb) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tv_q <= '0;
    else        tv_q <= {tv_q[LAT-2:0], issue};
    tb_q[0] <= cur_bank;
    ti_q[0] <= iss_n[IW-1:0];
    for (int k = 1; k < LAT; k++) begin
      tb_q[k] <= tb_q[k-1];
      ti_q[k] <= ti_q[k-1];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0] cnt;
    logic [CW:0]   gap;
    assign bank_free[b] = (cnt == '0);
    always_ff @(posedge clk) begin
      if (!rst_n)                            cnt <= '0;
      else if (issue && cur_bank == BW'(b))  cnt <= CW'(BUSY - 1);
      else if (cnt != '0)                    cnt <= cnt - 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                 gap <= (CW+1)'(BUSY);
      else if (bank_req[b])       gap <= (CW+1)'(1);
      else if (gap < (CW+1)'(BUSY)) gap <= gap + 1'b1;
    end
    AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      bank_req[b] |-> gap >= (CW+1)'(BUSY)); // R3
  end

  logic          chk_have;
  logic [AW-1:0] chk_last;
  logic [IW-1:0] chk_idx;
  always_ff @(posedge clk) begin
    if (!rst_n || take) begin
      chk_have <= 1'b0;
      chk_last <= '0;
      chk_idx  <= '0;
    end else begin
      if (|bank_req) begin
        chk_have <= 1'b1;
        chk_last <= bank_addr;
      end
      if (wb_valid) chk_idx <= chk_idx + 1'b1;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_req && chk_have) |-> bank_addr == chk_last + stride_q); // R2
  AST_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx == chk_idx); // R7
  AST_WB_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> bank_rvalid[tb_q[LAT-1]]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bank_req == '0 && !wb_valid)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R8

endmodule

// File: tb/strided_load_sched_test.sv
module strided_load_sched_test;
  localparam int LAT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_base = '0, cmd_stride = '0;
  logic [6:0]  cmd_len = '0;
  logic cmd_ready, done, wb_valid;
  logic [15:0] bank_req, bank_rvalid;
  logic [31:0] bank_addr;
  logic [1023:0] bank_rdata;
  logic [5:0]  wb_idx;
  logic [63:0] wb_data;

  strided_load_sched uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
    .cmd_stride(cmd_stride), .cmd_len(cmd_len), .cmd_ready(cmd_ready), .done(done),
    .bank_req(bank_req), .bank_addr(bank_addr), .bank_rvalid(bank_rvalid),
    .bank_rdata(bank_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, ncyc = 0;
  bit finished = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  function automatic logic [63:0] dat(input logic [31:0] a);
    return {a ^ 32'h5A5AC3C3, ~a};
  endfunction

  // bank model: fixed latency, one shared pipe (only one request per cycle)
  logic [LAT-1:0] pv;
  logic [31:0]    pa [LAT];
  always @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[LAT-2:0], |bank_req};
    pa[0] <= bank_addr;
    for (int k = 1; k < LAT; k++) pa[k] <= pa[k-1];
  end
  always @* begin
    bank_rvalid = '0;
    bank_rdata  = '0;
    for (int b = 0; b < 16; b++)
      if (pv[LAT-1] && pa[LAT-1][3:0] == 4'(b)) begin
        bank_rvalid[b] = 1'b1;
        bank_rdata[b*64 +: 64] = dat(pa[LAT-1]);
      end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // logs filled at negedges; edge number = ncyc+1
  int iss_e [64];
  logic [31:0] iss_a [64];
  int n_iss = 0;
  int wb_e [64];
  int wb_i [64];
  logic [63:0] wb_d [64];
  int n_wb = 0;
  int lastreq [16];
  initial for (int b = 0; b < 16; b++) lastreq[b] = -100;

  always @(negedge clk) if (rst_n) begin
    if (bank_req != '0) begin
      chk($onehot(bank_req) && bank_req[bank_addr[3:0]], "R1 request one-hot on addr bank", 64'(bank_req), 64'(16'h1 << bank_addr[3:0]));
      chk((ncyc + 1 - lastreq[bank_addr[3:0]]) >= 4, "R3 bank busy spacing", 64'(ncyc + 1 - lastreq[bank_addr[3:0]]), 64'd4);
      lastreq[bank_addr[3:0]] = ncyc + 1;
      if (n_iss < 64) begin iss_e[n_iss] = ncyc + 1; iss_a[n_iss] = bank_addr; end
      n_iss++;
    end
    if (wb_valid) begin
      if (n_wb < 64) begin wb_e[n_wb] = ncyc + 1; wb_i[n_wb] = int'(wb_idx); wb_d[n_wb] = wb_data; end
      n_wb++;
    end
  end

  task automatic run(input logic [31:0] base, input logic [31:0] stride, input int len,
                     input string rq, input bit poke);
    int eff, a_edge, t, done_at, last_wb;
    int exp_e [64];
    int lb [16];
    logic [31:0] ad;
    eff = (len > 64) ? 64 : len;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    n_iss = 0; n_wb = 0;
    cmd_valid = 1'b1; cmd_base = base; cmd_stride = stride; cmd_len = 7'(len);
    a_edge = ncyc + 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk(cmd_ready == 1'b0, "R8 not ready while busy", 64'(cmd_ready), 64'd0);
        cmd_valid = 1'b1; cmd_base = 32'hDEAD0000; cmd_stride = 32'd16; cmd_len = 7'd1;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    for (int b = 0; b < 16; b++) lb[b] = -100;
    t = a_edge + 1;
    for (int i = 0; i < eff; i++) begin
      ad = base + stride * 32'(i);
      if (t < lb[ad[3:0]] + 4) t = lb[ad[3:0]] + 4;
      exp_e[i] = t; lb[ad[3:0]] = t; t++;
    end
    last_wb = (eff == 0) ? a_edge : exp_e[eff-1] + LAT;
    done_at = -1;
    for (int k = 0; k < 2000 && done_at < 0; k++) begin
      if (done) done_at = ncyc; else @(negedge clk);
    end
    chk(done_at == last_wb, "R8 done timing", 64'(done_at), 64'(last_wb));
    chk(n_iss == eff, {rq, " issue count"}, 64'(n_iss), 64'(eff));
    chk(n_wb == eff, "R7 write-back count", 64'(n_wb), 64'(eff));
    for (int i = 0; i < eff && i < n_iss && i < n_wb; i++) begin
      ad = base + stride * 32'(i);
      chk(iss_a[i] == ad, "R2 element address", 64'(iss_a[i]), 64'(ad));
      chk(iss_e[i] == exp_e[i], {rq, " issue cycle"}, 64'(iss_e[i] - a_edge), 64'(exp_e[i] - a_edge));
      chk(wb_e[i] == iss_e[i] + LAT, "R7 write-back latency", 64'(wb_e[i] - iss_e[i]), 64'(LAT));
      chk(wb_i[i] == i, "R7 write-back index", 64'(wb_i[i]), 64'(i));
      chk(wb_d[i] == dat(ad), "R7 write-back data", wb_d[i], dat(ad));
    end
    @(negedge clk);
    chk(done == 1'b1 && cmd_ready == 1'b1, "R8 done holds while idle", {62'd0, done, cmd_ready}, 64'd3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 reset ready", 64'(cmd_ready), 64'd1);
    chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
    chk(bank_req == '0 && !wb_valid, "R10 reset quiet", {47'd0, wb_valid, bank_req}, 64'd0);
  endtask

  task automatic t_unit;      run(32'h100, 32'd1, 16, "R6 odd stride full rate", 0); endtask
  task automatic t_same_bank; run(32'h203, 32'd16, 8, "R5 stride 16 every 4 cycles", 0); endtask
  task automatic t_wide16;    run(32'h7, 32'd32, 5, "R5 stride 32 every 4 cycles", 0); endtask
  task automatic t_two_bank;  run(32'h40, 32'd8, 8, "R4 stride 8 stall pattern", 0); endtask
  task automatic t_wrap;      run(32'hFFFF_FFF0, 32'd3, 20, "R6 odd stride wrap", 0); endtask
  task automatic t_down;      run(32'h55, 32'hFFFF_FFFF, 10, "R6 negative stride", 0); endtask
  task automatic t_empty;     run(32'h10, 32'd1, 0, "R9 empty load", 0); endtask
  task automatic t_clamp;     run(32'h0, 32'd5, 100, "R9 length clamp", 0); endtask
  task automatic t_poke;      run(32'h300, 32'd2, 12, "R8 busy command ignored", 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_unit;
    t_same_bank;
    t_wide16;
    t_two_bank;
    t_wrap;
    t_down;
    t_empty;
    t_clamp;
    t_poke;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule